// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns several serial audio data lines into parallel stereo samples. All lines share one bit clock and one frame clock. Every line is framed the same way, so each line yields one stereo pair. A mode field selects the framing: right-justified, left-justified, I2S or DSP (single frame pulse). A word-length field selects 16, 20, 24 or 32 bits. A polarity bit chooses the bit-clock edge on which data and the frame clock are sampled.

The frame-clock control bit has two meanings, depending on the mode. In the three two-level formats it swaps which frame-clock level marks the left channel. In DSP mode it selects early or late alignment of the first data bit. Each pair has its own phase-reverse bit, which negates that pair's samples. Received words come out sign-extended to 32 bits, and a valid strobe is raised when both words of a frame are complete.

The serial inputs are oversampled by the system clock through a short synchroniser. The bit clock must therefore be several times slower than the system clock. Configuration is expected to stay constant while a stream is running; it is changed only under reset.

Top module: `aud_serial_rx`

## Requirements
- R1: With `fmt_i`=01 (left-justified), the left word is taken MSB first from the first bit period after the frame-clock edge that opens the left half. With `lr_ctl_i`=0, frame clock high marks left.
- R2: With `fmt_i`=10 (I2S), the word starts one bit period after the frame-clock edge. With `lr_ctl_i`=0, frame clock low marks left.
- R3: With `fmt_i`=00 (right-justified), the word's LSB sits in the last bit period before the frame-clock edge that closes the half. With `lr_ctl_i`=0, frame clock high marks left.
- R4: `wlen_i` selects 16 (00), 20 (01), 24 (10) or 32 (11) bits, and every output word is the received word sign-extended to 32 bits.
- R5: The combination `fmt_i`=00 with `wlen_i`=11 raises `cfg_err_o`, and no valid strobe is produced while it holds.
- R6: With `bclk_inv_i`=0, data and the frame clock are sampled on rising bit-clock edges. With `bclk_inv_i`=1, they are sampled on falling edges.
- R7: In the modes of R1, R2 and R3, `lr_ctl_i`=1 inverts which frame-clock level marks the left channel.
- R8: With `fmt_i`=11 (DSP), a rising frame clock marks the frame start. With `lr_ctl_i`=0 (early), the left MSB is in the bit period where the frame clock is first high. With `lr_ctl_i`=1 (late), it is in the following period. The right word follows the left word with no gap.
- R9: Line k of `sdata_i` feeds pair k (`left_o`/`right_o` slice [32k+31:32k]). All pairs are captured in parallel and strobe together.
- R10: Setting `rev_i[k]` negates pair k's output words. Negating the most negative 32-bit value gives 32'h7FFF_FFFF.
- R11: `valid_o` pulses for one system clock once per complete frame, after the right word. A half-frame already in progress when reception starts is discarded. Outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame (left/right or frame-pulse) clock |
| sdata_i | input | NUM_LINES | Serial data lines |
| fmt_i | input | 2 | Framing select (00 RJ, 01 LJ, 10 I2S, 11 DSP) |
| wlen_i | input | 2 | Word length select |
| bclk_inv_i | input | 1 | Sampling edge select |
| lr_ctl_i | input | 1 | Left-level inversion, or DSP late alignment |
| rev_i | input | NUM_LINES | Per-pair phase reverse |
| left_o | output | 32*NUM_LINES | Left words, sign-extended |
| right_o | output | 32*NUM_LINES | Right words, sign-extended |
| valid_o | output | NUM_LINES | Per-pair sample strobe |
| cfg_err_o | output | 1 | Unsupported format/length combination |

## Verification
The bench uses the default NUM_LINES=3 and SYNC_STAGES=2, so all three pairs are checked together and the sampling delay through the synchroniser is exercised. Each bit period lasts six system clocks, and each half-frame is 36 bit periods. That leaves room for the 32-bit I2S word, which starts one period late, and for a late-aligned 32-bit DSP frame of 65 bit periods. Every format, word length and control-bit value is run with random data, a random sampling edge and random phase reverse. Directed most-negative words exercise the saturation case.

// File: rtl/asr_pkg.sv
package asr_pkg;

  localparam int OUT_W = 32;
  localparam int IDX_W = 7;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } asr_fmt_e;

  // number of bits in a word for a length code
  function automatic logic [IDX_W-1:0] asr_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return IDX_W'(16);
      2'd1:    return IDX_W'(20);
      2'd2:    return IDX_W'(24);
      default: return IDX_W'(32);
    endcase
  endfunction

  // sign-extend the low bits of a raw shift register
  function automatic logic [OUT_W-1:0] asr_extend(input logic [OUT_W-1:0] raw,
                                                  input logic [1:0] wl);
    case (wl)
      2'd0:    return {{16{raw[15]}}, raw[15:0]};
      2'd1:    return {{12{raw[19]}}, raw[19:0]};
      2'd2:    return {{8{raw[23]}}, raw[23:0]};
      default: return raw;
    endcase
  endfunction

  // two's complement negation, clamped at the most negative value
  function automatic logic [OUT_W-1:0] asr_negate(input logic [OUT_W-1:0] v);
    if (v == {1'b1, {(OUT_W-1){1'b0}}}) return {1'b0, {(OUT_W-1){1'b1}}};
    return ~v + OUT_W'(1);
  endfunction

  function automatic logic [OUT_W-1:0] asr_shape(input logic [OUT_W-1:0] raw,
                                                 input logic [1:0] wl,
                                                 input logic rev);
    logic [OUT_W-1:0] ext;
    ext = asr_extend(raw, wl);
    return rev ? asr_negate(ext) : ext;
  endfunction

endpackage

// File: rtl/asr_sampler.sv
module asr_sampler #(
  parameter int NUM_LINES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk,
  input  logic                 lrclk,
  input  logic [NUM_LINES-1:0] sdata,
  input  logic                 bclk_inv,
  output logic                 stb,
  output logic                 lr_smp,
  output logic [NUM_LINES-1:0] dat_smp
);
  localparam int VEC_W = NUM_LINES + 2;

  logic [SYNC_STAGES-1:0][VEC_W-1:0] sync_q;
  logic                              nb_prev_q;
  logic [VEC_W-1:0]                  last_v;
  logic                              nb_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      nb_prev_q <= 1'b1;
    end else begin
      sync_q[0] <= {bclk, lrclk, sdata};
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      nb_prev_q <= nb_now;
    end
  end

  assign last_v  = sync_q[SYNC_STAGES-1];
  assign nb_now  = last_v[VEC_W-1] ^ bclk_inv;
  assign stb     = nb_now & ~nb_prev_q;
  assign lr_smp  = last_v[NUM_LINES];
  assign dat_smp = last_v[NUM_LINES-1:0];
endmodule

// File: rtl/asr_framer.sv
module asr_framer
  import asr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic       lr,
  input  logic [1:0] fmt,
  input  logic [1:0] wlen,
  input  logic       lr_ctl,
  output logic       chg,
  output logic       shift_en,
  output logic       close_l,
  output logic       close_r,
  output logic       emit,
  output logic       cap_next,
  output logic       cfg_err
);
  logic             have_prev_q, lr_prev_q, locked_q, left_ok_q;
  logic [IDX_W-1:0] idx_q, idx_now, nbits, off, std_off;
  logic             is_dsp, is_i2s, is_rj, prev_left, lock_now;

  assign is_dsp = (fmt == FMT_DSP);
  assign is_i2s = (fmt == FMT_I2S);
  assign is_rj  = (fmt == FMT_RJ);
  assign nbits  = asr_bits(wlen);

  assign cfg_err  = is_rj && (wlen == 2'b11);
  assign cap_next = is_dsp;

  // frame boundary: any level change, or a rising pulse in DSP mode
  assign chg = stb && have_prev_q &&
               (is_dsp ? (lr && !lr_prev_q) : (lr != lr_prev_q));

  assign idx_now = chg ? '0 : ((idx_q == IDX_MAX) ? IDX_MAX : idx_q + IDX_W'(1));

  assign std_off   = is_i2s ? IDX_W'(1) : IDX_W'(0);
  assign off       = is_dsp ? {{(IDX_W-1){1'b0}}, lr_ctl} : std_off;
  assign prev_left = lr_prev_q ^ is_i2s ^ lr_ctl;
  assign lock_now  = locked_q || chg;

  always_comb begin
    if (is_dsp) begin
      shift_en = stb && lock_now && (idx_now >= off) && (idx_now < off + 2*nbits);
      close_l  = stb && lock_now && (idx_now == off + nbits - IDX_W'(1));
      close_r  = stb && lock_now && (idx_now == off + 2*nbits - IDX_W'(1));
    end else begin
      shift_en = stb && (is_rj || ((idx_now >= off) && (idx_now < off + nbits)));
      close_l  = chg && locked_q && prev_left;
      close_r  = chg && locked_q && !prev_left;
    end
  end

  assign emit = close_r && left_ok_q && !cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      lr_prev_q   <= 1'b0;
      locked_q    <= 1'b0;
      left_ok_q   <= 1'b0;
      idx_q       <= IDX_MAX;
    end else begin
      if (stb) begin
        have_prev_q <= 1'b1;
        lr_prev_q   <= lr;
        idx_q       <= idx_now;
      end
      if (chg) locked_q <= 1'b1;
      if (close_l)      left_ok_q <= 1'b1;
      else if (close_r) left_ok_q <= 1'b0;
    end
  end
endmodule

// File: rtl/asr_lane.sv
module asr_lane
  import asr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             shift_en,
  input  logic             close_l,
  input  logic             emit,
  input  logic             cap_next,
  input  logic [1:0]       wlen,
  input  logic             rev,
  output logic [OUT_W-1:0] left_w,
  output logic [OUT_W-1:0] right_w,
  output logic             valid
);
  logic [OUT_W-1:0] shreg_q, hold_l_q, sh_next, src;

  assign sh_next = shift_en ? {shreg_q[OUT_W-2:0], bit_in} : shreg_q;
  assign src     = cap_next ? sh_next : shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      hold_l_q <= '0;
      left_w   <= '0;
      right_w  <= '0;
      valid    <= 1'b0;
    end else begin
      shreg_q <= sh_next;
      valid   <= emit;
      if (close_l) hold_l_q <= src;
      if (emit) begin
        left_w  <= asr_shape(hold_l_q, wlen, rev);
        right_w <= asr_shape(src, wlen, rev);
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import asr_pkg::*;
#(
  parameter int NUM_LINES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_i,
  input  logic                       lrclk_i,
  input  logic [NUM_LINES-1:0]       sdata_i,
  input  logic [1:0]                 fmt_i,
  input  logic [1:0]                 wlen_i,
  input  logic                       bclk_inv_i,
  input  logic                       lr_ctl_i,
  input  logic [NUM_LINES-1:0]       rev_i,
  output logic [NUM_LINES*OUT_W-1:0] left_o,
  output logic [NUM_LINES*OUT_W-1:0] right_o,
  output logic [NUM_LINES-1:0]       valid_o,
  output logic                       cfg_err_o
);
  logic                 smp_stb, smp_lr;
  logic [NUM_LINES-1:0] smp_dat;
  logic                 frm_chg, frm_shift, frm_close_l, frm_close_r, frm_emit, frm_cap_next;

  asr_sampler #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_i), .lrclk(lrclk_i), .sdata(sdata_i),
    .bclk_inv(bclk_inv_i), .stb(smp_stb), .lr_smp(smp_lr), .dat_smp(smp_dat)
  );

  asr_framer framer_i (
    .clk(clk), .rst_n(rst_n), .stb(smp_stb), .lr(smp_lr), .fmt(fmt_i), .wlen(wlen_i),
    .lr_ctl(lr_ctl_i), .chg(frm_chg), .shift_en(frm_shift), .close_l(frm_close_l),
    .close_r(frm_close_r), .emit(frm_emit), .cap_next(frm_cap_next), .cfg_err(cfg_err_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    asr_lane lane_i (
      .clk(clk), .rst_n(rst_n), .bit_in(smp_dat[g]), .shift_en(frm_shift),
      .close_l(frm_close_l), .emit(frm_emit), .cap_next(frm_cap_next), .wlen(wlen_i),
      .rev(rev_i[g]), .left_w(left_o[g*OUT_W +: OUT_W]), .right_w(right_o[g*OUT_W +: OUT_W]),
      .valid(valid_o[g])
    );
  end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int NUM_LINES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stb,
  input logic                    emit,
  input logic                    cfg_err_o,
  input logic [1:0]              wlen_i,
  input logic [NUM_LINES-1:0]    rev_i,
  input logic [NUM_LINES*32-1:0] left_o,
  input logic [NUM_LINES-1:0]    valid_o
);
  // R5
  cfg_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && $past(cfg_err_o)) |-> (valid_o == '0));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o != '0) |=> (valid_o == '0));

  // R11
  valid_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o != '0) |-> $past(emit));

  // R11
  emit_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> stb);

  // R9
  lanes_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o == '0) || (valid_o == '1));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    // R10
    no_min_after_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[g] && rev_i[g]) |-> (left_o[g*32 +: 32] != 32'h8000_0000));

    // R4
    ext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[g] && !rev_i[g] && wlen_i == 2'b00) |->
        ($countones(left_o[g*32+15 +: 17]) == 0 || $countones(left_o[g*32+15 +: 17]) == 17));
  end
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .stb(smp_stb), .emit(frm_emit), .cfg_err_o(cfg_err_o),
  .wlen_i(wlen_i), .rev_i(rev_i), .left_o(left_o), .valid_o(valid_o)
);

// File: tb/aud_serial_rx_tb_top.sv
module aud_serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 3;
  localparam int HALF_BITS  = 36;
  localparam int FRAMES     = 3;
  localparam int LINES      = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bclk_i = 1'b0, lrclk_i = 1'b0;
  logic [2:0]       sdata_i = '0;
  logic [1:0]       fmt_i = '0, wlen_i = '0;
  logic             bclk_inv_i = 1'b0, lr_ctl_i = 1'b0;
  logic [2:0]       rev_i = '0;
  logic [95:0]      left_o, right_o;
  logic [2:0]       valid_o;
  logic             cfg_err_o;

  int tests = 0, fails = 0, rx_cnt = 0, cycles = 0;
  int cur_n = 16;
  string cur_tag = "R1";
  logic [31:0] wl_q [FRAMES][LINES];
  logic [31:0] wr_q [FRAMES][LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .bclk_inv_i(bclk_inv_i), .lr_ctl_i(lr_ctl_i),
    .rev_i(rev_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .cfg_err_o(cfg_err_o)
  );

  function automatic logic [31:0] exp_val(input logic [31:0] w, input int n, input logic rv);
    longint s;
    s = longint'(w & ((64'd1 << n) - 1));
    if (w[n-1]) s = s - (longint'(1) << n);
    if (rv) s = -s;
    if (s > 64'sd2147483647) s = 64'sd2147483647;
    return s[31:0];
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'b00:   return "R3";
      2'b01:   return "R1";
      2'b10:   return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o != '0) begin
      check(valid_o == 3'b111, "R9 lanes strobe together", {29'd0, valid_o}, 32'd7);
      if (rx_cnt < FRAMES) begin
        for (int k = 0; k < LINES; k++) begin
          check(left_o[k*32 +: 32] == exp_val(wl_q[rx_cnt][k], cur_n, rev_i[k]),
                {cur_tag, " left R4 R6 R7 R9 R10"}, left_o[k*32 +: 32],
                exp_val(wl_q[rx_cnt][k], cur_n, rev_i[k]));
          check(right_o[k*32 +: 32] == exp_val(wr_q[rx_cnt][k], cur_n, rev_i[k]),
                {cur_tag, " right R4 R6 R7 R9 R10"}, right_o[k*32 +: 32],
                exp_val(wr_q[rx_cnt][k], cur_n, rev_i[k]));
        end
      end
      rx_cnt++;
    end
  end

  task automatic period(input logic lr, input logic [2:0] d);
    @(negedge clk);
    bclk_i = bclk_inv_i; lrclk_i = lr; sdata_i = d;
    repeat (HALF_CLKS) @(negedge clk);
    bclk_i = ~bclk_inv_i;
    repeat (HALF_CLKS - 1) @(negedge clk);
  endtask

  task automatic send_frame(input int fi);
    logic left_lvl, lv;
    logic [2:0] d;
    left_lvl = (fmt_i == 2'b10) ^ ~lr_ctl_i ? 1'b0 : 1'b1;
    left_lvl = (fmt_i == 2'b10) ? lr_ctl_i : ~lr_ctl_i;
    for (int p = 0; p < 2*HALF_BITS; p++) begin
      d = '0;
      if (fmt_i == 2'b11) begin
        int q;
        lv = (p == 0);
        q = p - int'(lr_ctl_i);
        for (int k = 0; k < LINES; k++) begin
          if (q >= 0 && q < cur_n)               d[k] = wl_q[fi][k][cur_n-1-q];
          else if (q >= cur_n && q < 2*cur_n)    d[k] = wr_q[fi][k][2*cur_n-1-q];
        end
      end else begin
        int h, q;
        logic [31:0] w;
        h = p / HALF_BITS; q = p % HALF_BITS;
        lv = (h == 0) ? left_lvl : ~left_lvl;
        for (int k = 0; k < LINES; k++) begin
          w = (h == 0) ? wl_q[fi][k] : wr_q[fi][k];
          if (fmt_i == 2'b01 && q < cur_n)                  d[k] = w[cur_n-1-q];
          else if (fmt_i == 2'b10 && q >= 1 && q <= cur_n)  d[k] = w[cur_n-q];
          else if (fmt_i == 2'b00 && q >= HALF_BITS-cur_n)  d[k] = w[HALF_BITS-1-q];
        end
      end
      period(lv, d);
    end
  endtask

  task automatic run_group(input logic [1:0] f, input logic [1:0] wl, input logic ctl,
                           input logic inv, input logic [2:0] rv);
    logic left_lvl;
    logic [31:0] mask;
    @(negedge clk);
    rst_n = 1'b0;
    fmt_i = f; wlen_i = wl; lr_ctl_i = ctl; bclk_inv_i = inv; rev_i = rv;
    bclk_i = inv; lrclk_i = 1'b0; sdata_i = '0;
    cur_n = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 20 : (wl == 2'd2) ? 24 : 32;
    cur_tag = fmt_tag(f);
    mask = (cur_n == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_n) - 1);
    for (int fi = 0; fi < FRAMES; fi++)
      for (int k = 0; k < LINES; k++) begin
        wl_q[fi][k] = $urandom & mask;
        wr_q[fi][k] = $urandom & mask;
      end
    wl_q[0][0] = 32'd1 << (cur_n - 1);   // most negative word, R10 corner
    wr_q[1][1] = mask;                   // -1
    repeat (4) @(negedge clk);
    rx_cnt = 0;
    rst_n = 1'b1;
    left_lvl = (f == 2'b10) ? ctl : ~ctl;
    // leading partial half-frame that must be dropped (R11)
    if (f == 2'b11) begin
      for (int i = 0; i < 5; i++) period(1'b1, 3'b101);
      for (int i = 0; i < 5; i++) period(1'b0, 3'b010);
    end else begin
      for (int i = 0; i < 5; i++) period(left_lvl, 3'b111);
      for (int i = 0; i < 5; i++) period(~left_lvl, 3'b000);
    end
    for (int fi = 0; fi < FRAMES; fi++) send_frame(fi);
    for (int i = 0; i < 4; i++) period((f == 2'b11) ? 1'b0 : left_lvl, 3'b000);
    repeat (12) @(negedge clk);
    if (f == 2'b00 && wl == 2'b11) begin
      check(cfg_err_o == 1'b1, "R5 error flag", {31'd0, cfg_err_o}, 32'd1);
      check(rx_cnt == 0, "R5 no strobe", rx_cnt, 0);
    end else begin
      check(cfg_err_o == 1'b0, "R5 flag clear", {31'd0, cfg_err_o}, 32'd0);
      check(rx_cnt == FRAMES, "R11 one strobe per frame", rx_cnt, FRAMES);
    end
  endtask

  initial begin
    logic [2:0] rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(valid_o == '0, "R11 reset valid", {29'd0, valid_o}, 32'd0);
    check(left_o == '0 && right_o == '0, "R11 reset words", left_o[31:0], 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 4; f++)
      for (int wl = 0; wl < 4; wl++)
        for (int c = 0; c < 2; c++) begin
          rv = 3'($urandom);
          if (wl == 3 && c == 0) rv[0] = 1'b1;
          run_group(2'(f), 2'(wl), 1'(c), 1'($urandom), rv);
        end
    // directed: falling-edge sampling and full reverse (R6, R10)
    run_group(2'b01, 2'b11, 1'b0, 1'b1, 3'b111);
    run_group(2'b11, 2'b11, 1'b1, 1'b1, 3'b000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule